// File: doc/BRIEF.md
# Synthesizer Power-Down Control Sequencer

This block holds the power state of a frequency-synthesizer core. A serial-load front end hands it complete words. Each word arrives with a one-cycle load strobe. The three least significant bits of the word pick the target register. The block decodes the power-control register and takes the analog enables from it. These enables cover the charge pump, the differential amplifier, the reference input buffer and the RF input bias. The same register also gives the divider load-state force, the counter hold and the lock-detect reset.

Writes to the other registers are not decoded field by field, but the block tracks them. Leaving power-on, charge-pump power-down or counter reset takes an ordered series of writes, and a write to register 0 ends each series. Clearing a single bit does not bring the core back up. Two state machines hold this sequencing:

- **Power FSM.** States are `PS_POR`, `PS_ACTIVE`, `PS_CPDOWN` and `PS_RESUME`. Its transitions are:
  - POR release: `PS_POR` goes to `PS_ACTIVE`, or to `PS_CPDOWN` if the pump power-down bit is latched, on a register-0 write once the gate is met.
  - Pump down: `PS_ACTIVE` or `PS_RESUME` goes to `PS_CPDOWN` on a control write with bit 5 set.
  - Pump clear: `PS_CPDOWN` goes to `PS_RESUME` on a control write with bit 5 clear.
  - Resume: `PS_RESUME` goes to `PS_ACTIVE` on a register-0 write.
- **Counter FSM.** States are `CS_HELD`, `CS_ARMED` and `CS_FREE`. Its transitions are:
  - Hold: any state goes to `CS_HELD` on a control write with bit 3 set.
  - Arm: `CS_HELD` goes to `CS_ARMED` on a control write with bit 3 clear.
  - Release: `CS_ARMED` goes to `CS_FREE` on a register-0 write.

Top module: `synth_pwr_ctl`

## Requirements
- R1: The register select is `ld_word[2:0]`. The value 101 addresses the power-control register, and 000, 001 and 010 address registers 0, 1 and 2. Words with any other select change no output.
- R2: After reset every section is down. `cp_en`, `diffamp_en`, `refbuf_en` and `rfin_bias_en` are 0, while `cp_hiz`, `div_load`, `cnt_hold` and `lock_det_rst` are 1.
- R3: Power-on release needs three sticky flags, and only reset clears them. The first is a control write with bits 7, 6 and 5 all clear. The other two are a write to register 2 and a write to register 1. Release happens on a register-0 write made while all three flags are set. Until then every output keeps its R2 value.
- R4: Bits 7 and 6 both 1 power the differential amplifier down, and both 0 power it up. If the two bits differ, the amplifier keeps its previous state.
- R5: A control write with bit 5 set enters pump power-down. It clears `cp_en`, `refbuf_en` and `rfin_bias_en`, and sets `cp_hiz`, `div_load` and `lock_det_rst`. The amplifier state is left as bits 7 and 6 give it.
- R6: During pump power-down, words for every register are still accepted. Once bit 5 is cleared, the core returns to active only on a later register-0 write.
- R7: Bit 4 drives `cp_hiz` high while active and powers down nothing else.
- R8: Bit 3 set raises `cnt_hold`. After bit 3 is cleared, `cnt_hold` falls only on a later register-0 write.
- R9: Outputs change only on the clock edge that samples the load strobe high. With the strobe low, no output moves.
- R10: If bit 5 is set when power-on release happens, the core enters pump power-down instead of active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ld_stb | input | 1 | One-cycle strobe that marks a loaded word |
| ld_word | input | WORD_W | Loaded word; bits 2:0 select the register |
| cp_en | output | 1 | Charge pump powered |
| cp_hiz | output | 1 | Charge-pump outputs tri-stated |
| diffamp_en | output | 1 | Differential amplifier powered |
| refbuf_en | output | 1 | Reference input buffer enabled |
| rfin_bias_en | output | 1 | RF input bias applied |
| div_load | output | 1 | Reference and feedback dividers forced to load state |
| cnt_hold | output | 1 | Counters held in reset |
| lock_det_rst | output | 1 | Lock-detect logic held in reset |

## Verification
A wrong power state shows at the ports on the first clock edge after the strobe that caused it. The enables are decoded straight from the state registers. A wrong gate flag or a wrong counter-FSM state stays hidden until the next register-0 write. At that write, release or counter freeing happens too early or never. For this reason the bench ends every sequence with a register-0 write and checks the outputs one cycle later.

// File: rtl/synth_pwr_pkg.sv
package synth_pwr_pkg;

    localparam int SEL_W     = 3;
    localparam int FIELD_W   = 8;
    localparam int BIT_CNT   = 3;
    localparam int BIT_TRI   = 4;
    localparam int BIT_CPPD  = 5;
    localparam int BIT_DA_LO = 6;
    localparam int BIT_DA_HI = 7;

    localparam logic [SEL_W-1:0] SEL_R0 = 3'b000;
    localparam logic [SEL_W-1:0] SEL_R1 = 3'b001;
    localparam logic [SEL_W-1:0] SEL_R2 = 3'b010;
    localparam logic [SEL_W-1:0] SEL_PD = 3'b101;

    typedef enum logic [1:0] {
        PS_POR,
        PS_ACTIVE,
        PS_CPDOWN,
        PS_RESUME
    } pwr_state_e;

    typedef enum logic [1:0] {
        CS_HELD,
        CS_ARMED,
        CS_FREE
    } cnt_state_e;

    typedef struct packed {
        logic wr_r0;
        logic wr_r1;
        logic wr_r2;
        logic wr_pd;
    } wr_hits_t;

    typedef struct packed {
        logic da_hi;
        logic da_lo;
        logic cp_pd;
        logic cp_tri;
        logic cnt_rst;
    } pd_bits_t;

endpackage

// File: rtl/pd_word_decode.sv
module pd_word_decode
    import synth_pwr_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              ld_stb,
    input  logic [WORD_W-1:0] ld_word,
    output wr_hits_t          hits,
    output pd_bits_t          bits
);

    logic [SEL_W-1:0] sel;

    assign sel = ld_word[SEL_W-1:0];

    always_comb begin
        hits.wr_r0 = ld_stb && (sel == SEL_R0);
        hits.wr_r1 = ld_stb && (sel == SEL_R1);
        hits.wr_r2 = ld_stb && (sel == SEL_R2);
        hits.wr_pd = ld_stb && (sel == SEL_PD);
    end

    always_comb begin
        bits.da_hi   = ld_word[BIT_DA_HI];
        bits.da_lo   = ld_word[BIT_DA_LO];
        bits.cp_pd   = ld_word[BIT_CPPD];
        bits.cp_tri  = ld_word[BIT_TRI];
        bits.cnt_rst = ld_word[BIT_CNT];
    end

    generate
        if (WORD_W > FIELD_W) begin : g_upper
            logic unused_upper;
            assign unused_upper = ^ld_word[WORD_W-1:FIELD_W];
        end
    endgenerate

endmodule

// File: rtl/por_gate.sv
module por_gate #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_req,
    output logic             gate_ok
);

    logic [NFLAG-1:0] seen_q;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    seen_q[i] <= 1'b0;
                end else if (set_req[i]) begin
                    seen_q[i] <= 1'b1;
                end
            end
        end
    endgenerate

    assign gate_ok = &seen_q;

endmodule

// File: rtl/pd_field_regs.sv
module pd_field_regs
    import synth_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_pd,
    input  pd_bits_t bits,
    output logic     da_pd_q,
    output logic     tri_q,
    output logic     cppd_q
);

    logic da_pd_d;

    always_comb begin
        da_pd_d = da_pd_q;
        if (bits.da_hi && bits.da_lo) begin
            da_pd_d = 1'b1;
        end else if (!bits.da_hi && !bits.da_lo) begin
            da_pd_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            da_pd_q <= 1'b1;
            tri_q   <= 1'b1;
            cppd_q  <= 1'b1;
        end else if (wr_pd) begin
            da_pd_q <= da_pd_d;
            tri_q   <= bits.cp_tri;
            cppd_q  <= bits.cp_pd;
        end
    end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import synth_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_r0,
    input  logic       wr_pd,
    input  logic       pd_bit,
    input  logic       cppd_q,
    input  logic       gate_ok,
    output pwr_state_e state_q
);

    pwr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_POR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_POR: begin
                if (wr_r0 && gate_ok) begin
                    state_d = cppd_q ? PS_CPDOWN : PS_ACTIVE;
                end
            end
            PS_ACTIVE: begin
                if (wr_pd && pd_bit) begin
                    state_d = PS_CPDOWN;
                end
            end
            PS_CPDOWN: begin
                if (wr_pd && !pd_bit) begin
                    state_d = PS_RESUME;
                end
            end
            PS_RESUME: begin
                if (wr_pd && pd_bit) begin
                    state_d = PS_CPDOWN;
                end else if (wr_r0) begin
                    state_d = PS_ACTIVE;
                end
            end
            default: state_d = PS_POR;
        endcase
    end

endmodule

// File: rtl/cnt_seq_fsm.sv
module cnt_seq_fsm
    import synth_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_r0,
    input  logic       wr_pd,
    input  logic       rst_bit,
    output cnt_state_e state_q
);

    cnt_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_HELD: begin
                if (wr_pd && !rst_bit) begin
                    state_d = CS_ARMED;
                end
            end
            CS_ARMED: begin
                if (wr_pd && rst_bit) begin
                    state_d = CS_HELD;
                end else if (wr_r0) begin
                    state_d = CS_FREE;
                end
            end
            CS_FREE: begin
                if (wr_pd && rst_bit) begin
                    state_d = CS_HELD;
                end
            end
            default: state_d = CS_HELD;
        endcase
    end

endmodule

// File: rtl/synth_pwr_ctl.sv
module synth_pwr_ctl
    import synth_pwr_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic [WORD_W-1:0] ld_word,
    output logic              cp_en,
    output logic              cp_hiz,
    output logic              diffamp_en,
    output logic              refbuf_en,
    output logic              rfin_bias_en,
    output logic              div_load,
    output logic              cnt_hold,
    output logic              lock_det_rst
);

    localparam int NFLAG = 3;

    wr_hits_t         hits;
    pd_bits_t         bits;
    logic             da_pd_q;
    logic             tri_q;
    logic             cppd_q;
    logic             gate_ok;
    logic [NFLAG-1:0] gate_set;
    pwr_state_e       pwr_q;
    cnt_state_e       cnt_q;

    pd_word_decode #(.WORD_W(WORD_W)) u_dec (
        .ld_stb (ld_stb),
        .ld_word(ld_word),
        .hits   (hits),
        .bits   (bits)
    );

    pd_field_regs u_fields (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_pd  (hits.wr_pd),
        .bits   (bits),
        .da_pd_q(da_pd_q),
        .tri_q  (tri_q),
        .cppd_q (cppd_q)
    );

    assign gate_set[0] = hits.wr_pd && !bits.da_hi && !bits.da_lo && !bits.cp_pd;
    assign gate_set[1] = hits.wr_r2;
    assign gate_set[2] = hits.wr_r1;

    por_gate #(.NFLAG(NFLAG)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(gate_set),
        .gate_ok(gate_ok)
    );

    pwr_seq_fsm u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_r0  (hits.wr_r0),
        .wr_pd  (hits.wr_pd),
        .pd_bit (bits.cp_pd),
        .cppd_q (cppd_q),
        .gate_ok(gate_ok),
        .state_q(pwr_q)
    );

    cnt_seq_fsm u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_r0  (hits.wr_r0),
        .wr_pd  (hits.wr_pd),
        .rst_bit(bits.cnt_rst),
        .state_q(cnt_q)
    );

    always_comb begin
        cp_en        = 1'b0;
        cp_hiz       = 1'b1;
        diffamp_en   = 1'b0;
        refbuf_en    = 1'b0;
        rfin_bias_en = 1'b0;
        div_load     = 1'b1;
        cnt_hold     = 1'b1;
        lock_det_rst = 1'b1;
        unique case (pwr_q)
            PS_POR: begin
            end
            PS_ACTIVE: begin
                cp_en        = 1'b1;
                cp_hiz       = tri_q;
                diffamp_en   = !da_pd_q;
                refbuf_en    = 1'b1;
                rfin_bias_en = 1'b1;
                div_load     = 1'b0;
                cnt_hold     = (cnt_q != CS_FREE);
                lock_det_rst = 1'b0;
            end
            PS_CPDOWN, PS_RESUME: begin
                diffamp_en = !da_pd_q;
                cnt_hold   = (cnt_q != CS_FREE);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/synth_pwr_ctl_chk.sv
module synth_pwr_ctl_chk #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_stb,
    input logic [WORD_W-1:0] ld_word,
    input logic              cp_en,
    input logic              cp_hiz,
    input logic              diffamp_en,
    input logic              refbuf_en,
    input logic              rfin_bias_en,
    input logic              div_load,
    input logic              cnt_hold,
    input logic              lock_det_rst
);

    logic wr5;
    logic wr0;

    assign wr5 = ld_stb && (ld_word[2:0] == 3'b101);
    assign wr0 = ld_stb && (ld_word[2:0] == 3'b000);

    // R5
    pump_down_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr5 && ld_word[5]) |=> (!cp_en && cp_hiz && div_load && lock_det_rst
                                 && !refbuf_en && !rfin_bias_en));

    // R6
    resume_on_r0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_en && !wr0) |=> !cp_en);

    // R4
    amp_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr5 && ld_word[7] && ld_word[6]) |=> !diffamp_en);

    // R4
    amp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr5 && (ld_word[7] != ld_word[6])) |=> $stable(diffamp_en));

    // R7
    tri_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr5 && ld_word[4]) |=> cp_hiz);

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hold && !wr0) |=> cnt_hold);

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_stb |=> ($stable(cp_en) && $stable(cp_hiz) && $stable(diffamp_en)
                     && $stable(refbuf_en) && $stable(rfin_bias_en)
                     && $stable(div_load) && $stable(cnt_hold)
                     && $stable(lock_det_rst)));

endmodule

bind synth_pwr_ctl synth_pwr_ctl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_stb      (ld_stb),
    .ld_word     (ld_word),
    .cp_en       (cp_en),
    .cp_hiz      (cp_hiz),
    .diffamp_en  (diffamp_en),
    .refbuf_en   (refbuf_en),
    .rfin_bias_en(rfin_bias_en),
    .div_load    (div_load),
    .cnt_hold    (cnt_hold),
    .lock_det_rst(lock_det_rst)
);

// File: tb/sim_synth_pwr_ctl.sv
module sim_synth_pwr_ctl;

    localparam int WORD_W = 24;
    localparam int NV     = 35;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_stb = 1'b0;
    logic [WORD_W-1:0] ld_word = '0;
    logic cp_en, cp_hiz, diffamp_en, refbuf_en, rfin_bias_en, div_load, cnt_hold, lock_det_rst;

    always #5 clk = ~clk;

    synth_pwr_ctl #(.WORD_W(WORD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_word(ld_word),
        .cp_en(cp_en), .cp_hiz(cp_hiz), .diffamp_en(diffamp_en),
        .refbuf_en(refbuf_en), .rfin_bias_en(rfin_bias_en),
        .div_load(div_load), .cnt_hold(cnt_hold), .lock_det_rst(lock_det_rst)
    );

    // Output vector: {cp_en, cp_hiz, diffamp_en, refbuf_en, rfin_bias_en, div_load, cnt_hold, lock_det_rst}
    logic [7:0] obs;
    assign obs = {cp_en, cp_hiz, diffamp_en, refbuf_en, rfin_bias_en, div_load, cnt_hold, lock_det_rst};

    // {requirement number, word, expected outputs after the write}
    localparam logic [35:0] VEC [NV] = '{
        {4'd3, 24'h000000, 8'h47},  // R3 register 0 before anything else
        {4'd3, 24'h000005, 8'h47},  // R3 control word clear
        {4'd3, 24'h000002, 8'h47},  // R3
        {4'd3, 24'h000001, 8'h47},  // R3
        {4'd3, 24'h000000, 8'hB8},  // R3 release
        {4'd7, 24'h000015, 8'hF8},  // R7 tri-state only
        {4'd4, 24'h000045, 8'hB8},  // R4 bits differ, amp stays on
        {4'd4, 24'h0000C5, 8'h98},  // R4 amp down
        {4'd4, 24'h000085, 8'h98},  // R4 bits differ, amp stays off
        {4'd5, 24'h000025, 8'h65},  // R5 pump down, amp back on
        {4'd6, 24'h000003, 8'h65},  // R6 other write accepted
        {4'd6, 24'h000000, 8'h65},  // R6 r0 while bit 5 still set
        {4'd6, 24'h000005, 8'h65},  // R6 cleared, still down
        {4'd6, 24'h000002, 8'h65},  // R6
        {4'd6, 24'h000000, 8'hB8},  // R6 resume
        {4'd8, 24'h00000D, 8'hBA},  // R8 hold
        {4'd8, 24'h000005, 8'hBA},  // R8 cleared, still held
        {4'd8, 24'h000001, 8'hBA},  // R8
        {4'd8, 24'h000000, 8'hB8},  // R8 release
        {4'd5, 24'h00002D, 8'h67},  // R5 pump down with hold
        {4'd8, 24'h000005, 8'h67},  // R8 armed in resume
        {4'd6, 24'h000000, 8'hB8},  // R6 both released
        {4'd5, 24'h000025, 8'h65},  // R5
        {4'd5, 24'h000025, 8'h65},  // R5 repeat
        {4'd6, 24'h000005, 8'h65},  // R6 resume pending
        {4'd6, 24'h000025, 8'h65},  // R6 re-enter pump down
        {4'd6, 24'h000000, 8'h65},  // R6 r0 ignored while down
        {4'd6, 24'h000005, 8'h65},  // R6
        {4'd6, 24'h000000, 8'hB8},  // R6
        {4'd1, 24'h0000FE, 8'hB8},  // R1 select 110 ignored
        {4'd1, 24'h0000EF, 8'hB8},  // R1 select 111 ignored
        {4'd5, 24'h0000E5, 8'h45},  // R5 pump and amp down
        {4'd6, 24'h0000C5, 8'h45},  // R6 cleared, amp still down
        {4'd6, 24'h000000, 8'h98},  // R6 active, amp down
        {4'd4, 24'h000005, 8'hB8}   // R4 amp up
    };

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input int req, input logic [7:0] exp, input string what);
        n_run++;
        if (obs !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, obs, exp);
        end
    endtask

    task automatic wr(input logic [WORD_W-1:0] w);
        @(negedge clk);
        ld_stb  = 1'b1;
        ld_word = w;
        @(negedge clk);
        ld_stb  = 1'b0;
        ld_word = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R9 watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(2, 8'h47, "reset state");  // R2

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][31:8]);
            check(int'(VEC[i][35:32]), VEC[i][7:0], $sformatf("vector %0d", i));
        end

        // R9: word with strobe low changes nothing
        @(negedge clk);
        ld_word = 24'h0000E5;
        repeat (3) @(negedge clk);
        ld_word = '0;
        check(9, 8'hB8, "no strobe");

        // R2: reset mid-run
        do_reset();
        check(2, 8'h47, "reset mid-run");

        // R3: control register never written clear, so no release
        wr(24'h000002);
        wr(24'h000001);
        wr(24'h000025);
        wr(24'h000000);
        check(3, 8'h47, "gate without clear control write");
        wr(24'h000005);
        check(3, 8'h47, "clear control write alone");
        wr(24'h000000);
        check(3, 8'hB8, "release with sticky flags");

        // R10: release while pump power-down bit latched
        do_reset();
        wr(24'h000005);
        wr(24'h000002);
        wr(24'h000001);
        wr(24'h000025);
        wr(24'h000000);
        check(10, 8'h65, "release into pump down");
        wr(24'h000005);
        check(6, 8'h65, "cleared after release");
        wr(24'h000000);
        check(6, 8'hB8, "resume after release");

        finish_run();
    end

endmodule